// File: doc/BRIEF.md
# Retriggerable Until-Rule Checker

This block watches three single-bit signals and judges, cycle by cycle, the rule "whenever the start signal is seen, the hold signal must stay high until the release signal arrives". Once start has been seen, the block opens an obligation. It keeps that obligation open over the following cycles, and it closes it in the cycle where release is high. A start in the same cycle as release closes the obligation at once, and in that case the hold signal is not examined.

Activations can overlap: a new start may arrive while an obligation is already open. All such activations share one release condition, so they are merged into a single open flag, and one release discharges all of them. The release is weak: an obligation that is never released is not an error. A violation is latched and stays visible until reset.

The status is reported on two registered outputs. They show the verdict for the input cycle just before the clock edge:

| valid | pending | meaning |
|-------|---------|---------|
| 0 | 0 | failed |
| 1 | 1 | an obligation is still open |
| 1 | 0 | satisfied, either because no obligation was ever opened or because every obligation has been released |

Top module: `until_mon`

## Requirements
- R1: After reset is released, and before any start, validOut=1 and pendingOut=0.
- R2: A cycle with startIn=1 and releaseIn=1 opens no obligation, even when holdIn=0. The next cycle shows validOut=1 and pendingOut=0.
- R3: A cycle with startIn=1, holdIn=1 and releaseIn=0 opens an obligation, so pendingOut=1 in the next cycle.
- R4: While an obligation is open, a cycle with holdIn=1 and releaseIn=0 keeps pendingOut=1 and validOut=1.
- R5: While an obligation is open, a cycle with releaseIn=1 discharges it whatever holdIn is, so the next cycle shows pendingOut=0 and validOut=1.
- R6: A cycle in which an obligation is open or startIn=1, while holdIn=0 and releaseIn=0, gives validOut=0 and pendingOut=0 in the next cycle.
- R7: Once validOut=0, it stays 0 and pendingOut stays 0 until reset, whatever the inputs do.
- R8: A start while an obligation is open merges into that obligation, and one release cycle discharges every merged activation.
- R9: An obligation that stays open for any number of cycles with holdIn=1 is never reported as a failure.
- R10: With no obligation open and startIn=0, holdIn and releaseIn have no effect: the outputs stay validOut=1 and pendingOut=0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock; all state changes on its rising edge |
| rstN | input | 1 | Active-low synchronous reset |
| startIn | input | 1 | Activates the rule in this cycle |
| holdIn | input | 1 | Operand that must stay high while an obligation is open |
| releaseIn | input | 1 | Operand that discharges open obligations |
| validOut | output | 1 | 0 once the rule has been violated |
| pendingOut | output | 1 | 1 while an obligation is open and unresolved |

## Verification
Two functions can fall in the same cycle: a fresh start and the release of an earlier obligation. The same holds for a start and a violation. The bench provokes both. It raises start together with release, both with and without an open obligation. It also raises start while holding the hold signal low. In the collision case the expected result is a closed obligation with validOut unchanged, and in the violation case a latched failure. Merged activations are judged by checking that a single release cycle brings pendingOut back to 0.

// File: rtl/until_mon_pkg.sv
package until_mon_pkg;

  // Strobes sent from the evaluation logic to the state registers.
  typedef struct packed {
    logic armOpen;    // obligation is open after this cycle
    logic dropOpen;   // obligation closed by release
    logic raiseFail;  // rule violated in this cycle
  } strobe_t;

endpackage

// File: rtl/until_mon_ctrl.sv
module until_mon_ctrl
  import until_mon_pkg::*;
(
  input  logic    clk,
  input  logic    rstN,
  input  logic    startIn,
  input  logic    holdIn,
  input  logic    releaseIn,
  input  logic    openState,
  input  logic    failState,
  output strobe_t strobe
);

  logic active;

  // The rule is live in a cycle when a start arrives or an obligation is carried in.
  assign active = startIn | openState;

  always_comb begin
    strobe = '0;
    if (!failState && active) begin
      if (releaseIn) begin
        strobe.dropOpen = 1'b1;
      end else if (holdIn) begin
        strobe.armOpen = 1'b1;
      end else begin
        strobe.raiseFail = 1'b1;
      end
    end
  end

  // A start with hold high and no release must leave an obligation open.
  assert_arm_R3: assert property (@(posedge clk) disable iff (!rstN)
    (startIn && holdIn && !releaseIn && !failState) |=> openState);

  // A live cycle with hold low and no release must latch a failure.
  assert_violate_R6: assert property (@(posedge clk) disable iff (!rstN)
    (active && !holdIn && !releaseIn) |=> (failState && !openState));

  // At most one strobe fires per cycle.
  assert_one_strobe_R8: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0(strobe));

endmodule

// File: rtl/until_mon_state.sv
module until_mon_state
  import until_mon_pkg::*;
(
  input  logic    clk,
  input  logic    rstN,
  input  logic    startIn,
  input  logic    releaseIn,
  input  strobe_t strobe,
  output logic    openState,
  output logic    failState
);

  always_ff @(posedge clk) begin
    if (!rstN) begin
      openState <= 1'b0;
      failState <= 1'b0;
    end else if (strobe.raiseFail) begin
      failState <= 1'b1;
      openState <= 1'b0;
    end else if (strobe.armOpen) begin
      openState <= 1'b1;
    end else if (strobe.dropOpen) begin
      openState <= 1'b0;
    end
  end

  // A failure is never withdrawn before reset.
  assert_fail_sticky_R7: assert property (@(posedge clk) disable iff (!rstN)
    failState |=> (failState && !openState));

  // A release while no failure is latched always closes the open flag.
  assert_release_R5: assert property (@(posedge clk) disable iff (!rstN)
    (releaseIn && !failState) |=> (!openState && !failState));

  // When idle, the state does not move.
  assert_idle_R10: assert property (@(posedge clk) disable iff (!rstN)
    (!openState && !startIn && !failState) |=> (!openState && !failState));

endmodule

// File: rtl/until_mon.sv
module until_mon
  import until_mon_pkg::*;
(
  input  logic clk,
  input  logic rstN,
  input  logic startIn,
  input  logic holdIn,
  input  logic releaseIn,
  output logic validOut,
  output logic pendingOut
);

  strobe_t strobe;
  logic    openState;
  logic    failState;

  until_mon_ctrl u_ctrl (
    .clk       (clk),
    .rstN      (rstN),
    .startIn   (startIn),
    .holdIn    (holdIn),
    .releaseIn (releaseIn),
    .openState (openState),
    .failState (failState),
    .strobe    (strobe)
  );

  until_mon_state u_state (
    .clk       (clk),
    .rstN      (rstN),
    .startIn   (startIn),
    .releaseIn (releaseIn),
    .strobe    (strobe),
    .openState (openState),
    .failState (failState)
  );

  assign validOut   = ~failState;
  assign pendingOut = openState;

  // The status outputs never show pending together with failed.
  assert_status_code_R7: assert property (@(posedge clk) disable iff (!rstN)
    !(pendingOut && !validOut));

endmodule

// File: tb/sim_until_mon.sv
module sim_until_mon;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic startIn = 1'b0;
  logic holdIn = 1'b0;
  logic releaseIn = 1'b0;
  logic validOut;
  logic pendingOut;

  int checks = 0;
  int fails = 0;

  always #5 clk = ~clk;

  until_mon u0 (
    .clk(clk), .rstN(rstN), .startIn(startIn), .holdIn(holdIn),
    .releaseIn(releaseIn), .validOut(validOut), .pendingOut(pendingOut)
  );

  // Each row holds {start, hold, release, expected valid, expected pending}.
  // The expected outputs are those seen after the edge that samples the row.
  localparam int NVEC = 15;
  localparam logic [4:0] VEC [NVEC] = '{
    5'b000_10, // R10 idle, hold low
    5'b111_10, // R2 start with release
    5'b101_10, // R2 start with release, hold low
    5'b110_11, // R3 arm
    5'b010_11, // R4 keep open
    5'b110_11, // R8 retrigger while open
    5'b001_10, // R5 release with hold low
    5'b000_10, // R10 idle
    5'b110_11, // R3 arm
    5'b110_11, // R8 merge second start
    5'b011_10, // R8 one release clears both
    5'b110_11, // R3 arm
    5'b000_00, // R6 hold drop before release
    5'b111_00, // R7 sticky
    5'b010_00  // R7 sticky
  };

  task automatic check(input string req, input logic gotV, input logic gotP,
                       input logic expV, input logic expP);
    checks++;
    if (gotV !== expV || gotP !== expP) begin
      fails++;
      $display("FAIL %s: valid/pending got %b%b expected %b%b", req, gotV, gotP, expV, expP);
    end
  endtask

  task automatic drive(input logic s, input logic h, input logic r);
    @(negedge clk);
    startIn = s; holdIn = h; releaseIn = r;
    @(negedge clk);
  endtask

  task automatic do_reset();
    @(negedge clk);
    rstN = 1'b0; startIn = 1'b0; holdIn = 1'b0; releaseIn = 1'b0;
    @(negedge clk);
    @(negedge clk);
    rstN = 1'b1;
  endtask

  initial begin : watchdog
    repeat (20000) @(posedge clk);
    fails++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    do_reset();
    @(negedge clk);
    check("R1", validOut, pendingOut, 1'b1, 1'b0);

    for (int i = 0; i < NVEC; i++) begin
      @(negedge clk);
      startIn = VEC[i][4]; holdIn = VEC[i][3]; releaseIn = VEC[i][2];
      @(negedge clk);
      check($sformatf("vector %0d", i), validOut, pendingOut, VEC[i][1], VEC[i][0]);
    end

    // R1: reset clears a latched failure.
    do_reset();
    @(negedge clk);
    check("R1 after failure", validOut, pendingOut, 1'b1, 1'b0);

    // R6: a start with hold low and no release fails immediately.
    drive(1'b1, 1'b0, 1'b0);
    check("R6 start with hold low", validOut, pendingOut, 1'b0, 1'b0);
    drive(1'b0, 1'b1, 1'b1);
    check("R7 release after failure", validOut, pendingOut, 1'b0, 1'b0);

    // R9: a weak until never releases yet never fails.
    do_reset();
    drive(1'b1, 1'b1, 1'b0);
    for (int k = 0; k < 500; k++) begin
      @(negedge clk);
      startIn = 1'b0; holdIn = 1'b1; releaseIn = 1'b0;
    end
    @(negedge clk);
    check("R9 long open obligation", validOut, pendingOut, 1'b1, 1'b1);
    drive(1'b1, 1'b0, 1'b1);
    check("R2 R5 start with release while open", validOut, pendingOut, 1'b1, 1'b0);

    // R10: the operands alone do nothing when idle.
    drive(1'b0, 1'b0, 1'b0);
    check("R10 idle after release", validOut, pendingOut, 1'b1, 1'b0);

    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

endmodule